// File: doc/BRIEF.md
# Deferred Invalidate Queue with Barrier Drain

This block sits in front of a cache tag array that cannot always accept an invalidation at the moment one arrives. Each incoming invalidate request is acknowledged in the same cycle it is presented. Its line address is then parked in a small in-order queue. Whenever the cache reports that it is free, the oldest parked address is handed to the tag array, one per cycle.

Until a parked address has been handed over, the surrounding protocol logic may not emit any coherence message about that line. A probe port therefore compares a candidate outgoing address with every parked entry and raises a block flag when any of them matches.

The block also closes two kinds of barrier:
- A read barrier completes once the queue is empty.
- A full barrier also needs an external flag that reports an empty store buffer.

When the queue is full, the acknowledge is withheld. The requester must hold its request until a slot frees.

Top module: `inv_defer_queue`

## Requirements
- R1: When `inv_valid_i` is high and fewer than DEPTH entries are parked, `inv_ack_o` is high in that same cycle and the address is parked at the following clock edge.
- R2: When DEPTH entries are parked, `inv_ack_o` stays low and nothing is parked. A held request is acknowledged in the first cycle after a slot has been freed.
- R3: Parked addresses leave on `apply_addr_o` in arrival order. `apply_valid_o` is high exactly in cycles where `cache_free_i` is high and at least one entry is parked, and one entry leaves per such cycle.
- R4: `probe_block_o` is high in a cycle exactly when `probe_addr_i` equals the address of some entry parked at the start of that cycle. An address that is only being presented on `inv_addr_i` in that cycle does not count.
- R5: If the same address is parked twice, `probe_block_o` for that address remains high until both copies have left.
- R6: With `bar_req_i` high and `bar_kind_i`=0 (read barrier), `bar_done_o` is high only when no entry is parked, whatever `sb_empty_i` is. `bar_stall_o` is high whenever `bar_req_i` is high and `bar_done_o` is low.
- R7: With `bar_req_i` high and `bar_kind_i`=1 (full barrier), `bar_done_o` is high only when no entry is parked and `sb_empty_i` is high.
- R8: A cycle that both parks a new entry and hands one over leaves the occupancy unchanged.
- R9: After reset, no entry is parked: `apply_valid_o` and `probe_block_o` are low, and a read barrier completes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid_i | input | 1 | Incoming invalidate request present |
| inv_addr_i | input | AW | Line address of the incoming invalidate |
| inv_ack_o | output | 1 | Acknowledge, same cycle as acceptance |
| cache_free_i | input | 1 | Tag array can take one invalidation this cycle |
| apply_valid_o | output | 1 | Oldest entry handed to the tag array this cycle |
| apply_addr_o | output | AW | Line address being invalidated |
| probe_addr_i | input | AW | Address of a candidate outgoing coherence message |
| probe_block_o | output | 1 | Candidate message must be held back |
| bar_req_i | input | 1 | A barrier is waiting |
| bar_kind_i | input | 1 | 0 = read barrier, 1 = full barrier |
| sb_empty_i | input | 1 | External store buffer is empty |
| bar_done_o | output | 1 | Barrier may complete this cycle |
| bar_stall_o | output | 1 | Barrier must keep waiting |

## Verification
The assertions assume that a requester whose invalidate was not acknowledged keeps presenting it. They also assume that `cache_free_i` is only an offer, so an offer made while the queue is empty has no effect. The stimulus holds the same address on `inv_valid_i` across every withheld cycle. It also raises `cache_free_i` both with and without parked entries. Barrier inputs change only between clock edges, and the bench reads the combinational outputs in the low phase of the clock.

// File: rtl/inv_defer_pkg.sv
package inv_defer_pkg;
   typedef enum logic {
      BAR_RD  = 1'b0,
      BAR_ALL = 1'b1
   } bar_kind_e;
endpackage

// File: rtl/inv_slot_ring.sv
module inv_slot_ring #(
   parameter int AW    = 32,
   parameter int DEPTH = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push,
   input  logic [AW-1:0]       push_addr,
   input  logic                pop,
   output logic [AW-1:0]       head_addr,
   output logic [DEPTH-1:0]    slot_vld,
   output logic [DEPTH*AW-1:0] slot_addr,
   output logic                full,
   output logic                empty
);
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW   = $clog2(DEPTH + 1);
   localparam bit POW2 = ((1 << PW) == DEPTH);

   logic [AW-1:0] mem [DEPTH];
   logic [PW-1:0] wptr, rptr, wptr_nxt, rptr_nxt;
   logic [CW-1:0] count;

   generate
      if (POW2) begin : g_wrap_nat
         assign wptr_nxt = wptr + 1'b1;
         assign rptr_nxt = rptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wptr_nxt = (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rptr_nxt = (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   assign full      = (count == CW'(DEPTH));
   assign empty     = (count == '0);
   assign head_addr = mem[rptr];

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= push_addr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr     <= '0;
         rptr     <= '0;
         count    <= '0;
         slot_vld <= '0;
      end else begin
         if (push) begin
            wptr           <= wptr_nxt;
            slot_vld[wptr] <= 1'b1;
         end
         if (pop) begin
            rptr           <= rptr_nxt;
            slot_vld[rptr] <= 1'b0;
         end
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_flat
         assign slot_addr[i*AW +: AW] = mem[i];
      end
   endgenerate

   // R2
   occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   // R4
   vld_count_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(slot_vld) == int'(count));

   // R1
   push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> (count == $past(count) + 1'b1));

   // R8
   push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> $stable(count));

   // R3
   pop_from_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> slot_vld[rptr]);
endmodule

// File: rtl/inv_addr_match.sv
module inv_addr_match #(
   parameter int AW    = 32,
   parameter int DEPTH = 4
) (
   input  logic [AW-1:0]       probe_addr,
   input  logic [DEPTH-1:0]    slot_vld,
   input  logic [DEPTH*AW-1:0] slot_addr,
   output logic                hit
);
   logic [DEPTH-1:0] hit_vec;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
         assign hit_vec[i] = slot_vld[i] && (slot_addr[i*AW +: AW] == probe_addr);
      end
   endgenerate

   assign hit = |hit_vec;

   // R4
   always_comb begin
      hit_needs_live_chk: assert (!hit || (|slot_vld));
   end
endmodule

// File: rtl/inv_bar_gate.sv
module inv_bar_gate
   import inv_defer_pkg::*;
(
   input  logic      req,
   input  bar_kind_e kind,
   input  logic      q_empty,
   input  logic      sb_empty,
   output logic      done,
   output logic      stall
);
   logic drained;

   always_comb begin
      case (kind)
         BAR_ALL: drained = q_empty && sb_empty;
         default: drained = q_empty;
      endcase
   end

   assign done  = req && drained;
   assign stall = req && !drained;

   // R6
   always_comb begin
      bar_waits_queue_chk: assert (!done || q_empty);
   end

   // R7
   always_comb begin
      full_bar_waits_sb_chk: assert (!(done && kind == BAR_ALL) || sb_empty);
   end
endmodule

// File: rtl/inv_defer_queue.sv
module inv_defer_queue
   import inv_defer_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inv_valid_i,
   input  logic [AW-1:0] inv_addr_i,
   output logic          inv_ack_o,
   input  logic          cache_free_i,
   output logic          apply_valid_o,
   output logic [AW-1:0] apply_addr_o,
   input  logic [AW-1:0] probe_addr_i,
   output logic          probe_block_o,
   input  logic          bar_req_i,
   input  logic          bar_kind_i,
   input  logic          sb_empty_i,
   output logic          bar_done_o,
   output logic          bar_stall_o
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("inv_defer_queue: DEPTH must be at least 2");
      end
      if (AW < 1) begin : g_bad_aw
         $error("inv_defer_queue: AW must be at least 1");
      end
   endgenerate

   logic                q_full, q_empty, do_push, do_pop;
   logic [DEPTH-1:0]    slot_vld;
   logic [DEPTH*AW-1:0] slot_addr;

   assign do_push       = inv_valid_i && !q_full;
   assign do_pop        = cache_free_i && !q_empty;
   assign inv_ack_o     = do_push;
   assign apply_valid_o = do_pop;

   inv_slot_ring #(.AW(AW), .DEPTH(DEPTH)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (do_push),
      .push_addr (inv_addr_i),
      .pop       (do_pop),
      .head_addr (apply_addr_o),
      .slot_vld  (slot_vld),
      .slot_addr (slot_addr),
      .full      (q_full),
      .empty     (q_empty)
   );

   inv_addr_match #(.AW(AW), .DEPTH(DEPTH)) u_match (
      .probe_addr (probe_addr_i),
      .slot_vld   (slot_vld),
      .slot_addr  (slot_addr),
      .hit        (probe_block_o)
   );

   inv_bar_gate u_bar (
      .req      (bar_req_i),
      .kind     (bar_kind_e'(bar_kind_i)),
      .q_empty  (q_empty),
      .sb_empty (sb_empty_i),
      .done     (bar_done_o),
      .stall    (bar_stall_o)
   );

   // R4
   block_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_block_o && !apply_valid_o) |=> (probe_block_o || $changed(probe_addr_i)));

   // R6
   drain_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_req_i && !bar_kind_i && !inv_ack_o && apply_valid_o && $countones(slot_vld) == 1)
      |=> (!bar_req_i || bar_kind_i || bar_done_o));

   // R2
   hold_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid_i && !inv_ack_o) |-> (&slot_vld));
endmodule

// File: tb/sim_inv_defer_queue.sv
module sim_inv_defer_queue;
   localparam int AW = 32;
   localparam int DEPTH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic inv_valid_i = 1'b0, cache_free_i = 1'b0;
   logic bar_req_i = 1'b0, bar_kind_i = 1'b0, sb_empty_i = 1'b0;
   logic [AW-1:0] inv_addr_i = '0, probe_addr_i = '0;
   logic inv_ack_o, apply_valid_o, probe_block_o, bar_done_o, bar_stall_o;
   logic [AW-1:0] apply_addr_o;

   int total = 0;
   int bad = 0;
   bit ended = 1'b0;

   always #10 clk = ~clk;

   inv_defer_queue #(.AW(AW), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n),
      .inv_valid_i(inv_valid_i), .inv_addr_i(inv_addr_i), .inv_ack_o(inv_ack_o),
      .cache_free_i(cache_free_i), .apply_valid_o(apply_valid_o), .apply_addr_o(apply_addr_o),
      .probe_addr_i(probe_addr_i), .probe_block_o(probe_block_o),
      .bar_req_i(bar_req_i), .bar_kind_i(bar_kind_i), .sb_empty_i(sb_empty_i),
      .bar_done_o(bar_done_o), .bar_stall_o(bar_stall_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic        vi;
      logic [15:0] va;
      logic        fr;
      logic [15:0] pr;
      logic        ack;
      logic        apv;
      logic [15:0] apa;
      logic        blk;
   } vec_t;

   // R1 R2 R3 R4 R5 R8: queue walk, DEPTH=4
   localparam vec_t TBL [13] = '{
      '{1'b1, 16'h0011, 1'b0, 16'h0011, 1'b1, 1'b0, 16'h0000, 1'b0},
      '{1'b1, 16'h0022, 1'b0, 16'h0011, 1'b1, 1'b0, 16'h0000, 1'b1},
      '{1'b1, 16'h0033, 1'b0, 16'h0022, 1'b1, 1'b0, 16'h0000, 1'b1},
      '{1'b1, 16'h0044, 1'b0, 16'h0055, 1'b1, 1'b0, 16'h0000, 1'b0},
      '{1'b1, 16'h0055, 1'b0, 16'h0044, 1'b0, 1'b0, 16'h0000, 1'b1},
      '{1'b1, 16'h0055, 1'b1, 16'h0055, 1'b0, 1'b1, 16'h0011, 1'b0},
      '{1'b1, 16'h0055, 1'b1, 16'h0011, 1'b1, 1'b1, 16'h0022, 1'b0},
      '{1'b0, 16'h0000, 1'b1, 16'h0055, 1'b0, 1'b1, 16'h0033, 1'b1},
      '{1'b0, 16'h0000, 1'b0, 16'h0044, 1'b0, 1'b0, 16'h0000, 1'b1},
      '{1'b1, 16'h0044, 1'b1, 16'h0044, 1'b1, 1'b1, 16'h0044, 1'b1},
      '{1'b0, 16'h0000, 1'b1, 16'h0044, 1'b0, 1'b1, 16'h0055, 1'b1},
      '{1'b0, 16'h0000, 1'b1, 16'h0044, 1'b0, 1'b1, 16'h0044, 1'b1},
      '{1'b0, 16'h0000, 1'b1, 16'h0044, 1'b0, 1'b0, 16'h0000, 1'b0}
   };

   task automatic finish_up();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      @(negedge clk);
      bar_req_i = 1'b1; bar_kind_i = 1'b0; probe_addr_i = '0;
      #2;
      check("R9 apply_valid", apply_valid_o, 0);
      check("R9 block", probe_block_o, 0);
      check("R9 bar_done", bar_done_o, 1);
      bar_req_i = 1'b0;

      // table walk
      for (int i = 0; i < 13; i++) begin
         @(negedge clk);
         inv_valid_i  = TBL[i].vi;
         inv_addr_i   = AW'(TBL[i].va);
         cache_free_i = TBL[i].fr;
         probe_addr_i = AW'(TBL[i].pr);
         #2;
         check("R1/R2 ack", inv_ack_o, TBL[i].ack);
         check("R3 apply_valid", apply_valid_o, TBL[i].apv);
         if (TBL[i].apv) check("R3 apply_addr", apply_addr_o, AW'(TBL[i].apa));
         check("R4/R5 block", probe_block_o, TBL[i].blk);
      end

      // R6 R7 barriers with two parked entries
      @(negedge clk);
      inv_valid_i = 1'b1; inv_addr_i = 32'h100; cache_free_i = 1'b0;
      @(negedge clk);
      inv_addr_i = 32'h200;
      @(negedge clk);
      inv_valid_i = 1'b0;
      bar_req_i = 1'b1; bar_kind_i = 1'b0; sb_empty_i = 1'b1;
      #2;
      check("R6 read bar waits", bar_done_o, 0);
      check("R6 read bar stall", bar_stall_o, 1);
      bar_kind_i = 1'b1;
      #1;
      check("R7 full bar waits queue", bar_done_o, 0);
      @(negedge clk);
      bar_kind_i = 1'b0; cache_free_i = 1'b1;
      #2;
      check("R6 pop first", apply_addr_o, 32'h100);
      check("R6 read bar not yet", bar_done_o, 0);
      @(negedge clk);
      #2;
      check("R6 pop last keeps wait", bar_done_o, 0);
      check("R3 pop last addr", apply_addr_o, 32'h200);
      @(negedge clk);
      cache_free_i = 1'b0; sb_empty_i = 1'b0;
      #2;
      check("R6 read bar done ignores sb", bar_done_o, 1);
      check("R6 read bar no stall", bar_stall_o, 0);
      bar_kind_i = 1'b1;
      #1;
      check("R7 full bar waits sb", bar_done_o, 0);
      check("R7 full bar stall", bar_stall_o, 1);
      sb_empty_i = 1'b1;
      #1;
      check("R7 full bar done", bar_done_o, 1);
      bar_req_i = 1'b0;
      #1;
      check("R6 no req no done", bar_done_o, 0);

      // R9 reset clears parked entries
      @(negedge clk);
      inv_valid_i = 1'b1; inv_addr_i = 32'h77;
      @(negedge clk);
      inv_valid_i = 1'b0; probe_addr_i = 32'h77;
      #2;
      check("R4 parked before reset", probe_block_o, 1);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      cache_free_i = 1'b1; bar_req_i = 1'b1; bar_kind_i = 1'b0;
      #2;
      check("R9 block after reset", probe_block_o, 0);
      check("R9 apply after reset", apply_valid_o, 0);
      check("R9 bar after reset", bar_done_o, 1);

      finish_up();
   end
endmodule